// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block merges a set of peripheral interrupt sources into one interrupt request line for a processor. Each source has a pending bit, an enable bit and a programmable priority. A rising edge on a source input latches its pending bit. The request line is raised only when an enabled, pending source sits strictly above the priority level currently in service. When several sources qualify, the one with the highest priority wins.

When the processor acknowledges, the block returns the winning source number. It clears that source's pending bit and stores the level in service on an internal last-in first-out stack. The winner's level then becomes the level in service, so only strictly higher sources can nest on top of it. An end-of-interrupt takes the most recently stored level back off the stack, which lets lower pending sources through again. Because nesting always climbs strictly, the stack needs one entry per priority value. Software reaches enables, pending status and priorities through a plain write port and a combinational read port.

Top module: `nest_prio_irq`

## Requirements
- R1: `irq_o` is high exactly when some source has pending=1, enable=1 and level (priority+1) greater than `cur_lvl_o`. After reset the level in service is 0, so any enabled pending source interrupts.
- R2: A source's pending bit is set by the clock edge at which its input is first sampled high after being low. A source held high does not set the bit again after an acknowledge has cleared it.
- R3: `ack_id_o` gives the eligible source with the highest level. Among equal levels the lowest source index wins. With no eligible source it is all ones (15 with default parameters).
- R4: An acknowledge with an eligible winner clears that winner's pending bit. At the next edge it makes the winner's level (priority+1) the level in service and stores the old level on the stack.
- R5: Sources whose level is equal to or below the level in service do not raise `irq_o`, and their pending bits are kept.
- R6: An end-of-interrupt with a non-empty stack restores the most recently stored level. A chain of nested acknowledges therefore unwinds in reverse order.
- R7: An end-of-interrupt with an empty stack leaves the level unchanged and sets `eoi_err_o`. The flag stays set until reset.
- R8: An acknowledge with no eligible source changes neither the level, the stack nor any pending bit.
- R9: Register map: address 0 holds the enables (bit i is source i), address 1 holds pending (read only, writes have no effect), and address 2+i holds source i's priority in the low PRIO_W bits. Unmapped addresses read 0.
- R10: A full chain of strictly rising acknowledges (levels 1 to 2^PRIO_W) nests completely, and the stack never holds more than 2^PRIO_W entries.
- R11: When acknowledge and end-of-interrupt arrive in the same cycle, the acknowledge is processed and the end-of-interrupt is dropped: no restore and no error.
- R12: A disabled source still latches pending. It raises the request as soon as it is enabled.
- R13: A rising edge that arrives in the same cycle as the acknowledge of that same source leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Peripheral interrupt inputs, edge detected |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | NSRC | Register write data |
| rd_addr_i | input | AW | Register read address |
| rd_data_o | output | NSRC | Register read data (combinational) |
| ack_i | input | 1 | Acknowledge: take the current winner |
| ack_id_o | output | IDW | Winning source number, all ones when none |
| eoi_i | input | 1 | End of interrupt: restore previous level |
| irq_o | output | 1 | Interrupt request to the processor |
| cur_lvl_o | output | PRIO_W+1 | Level currently in service (0 = idle) |
| eoi_err_o | output | 1 | Sticky flag for an end-of-interrupt on an empty stack |

## Verification
On every cycle, the embedded properties check the following. An edge always lands in the pending bit, and a cleared bit stays clear unless a fresh edge arrives. A stored level is always below the new one, and a restore always lowers the level. The stack never grows past its bound. A bad end-of-interrupt freezes the level and latches the flag. The request only names an enabled, pending source above the level in service. Which source wins among several candidates, the tie order, the reverse unwinding of a deep chain and the effect of register writes can only be seen in the bench's scenarios. The bench sweeps every source against every priority and every subset of pending sources, and compares the results with an arithmetic model.

// File: rtl/npi_pkg.sv
package npi_pkg;

  // Register addresses; priorities occupy a contiguous run after the base.
  localparam int REG_ENABLE    = 0;
  localparam int REG_PENDING   = 1;
  localparam int REG_PRIO_BASE = 2;

  // Address of the priority register of a given source.
  function automatic int prio_addr(input int src_idx);
    return REG_PRIO_BASE + src_idx;
  endfunction

endpackage

// File: rtl/npi_pend.sv
module npi_pend #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] rise_o,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] pend_q;

  // A source counts as new when it is high now and was low last cycle.
  assign rise_o = src_i & ~src_q;
  assign pend_o = pend_q;

  // A fresh edge wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_i) | rise_o;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    // R2
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> pend_q[g]);
    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !rise_o[g]) |=> !pend_q[g]);
  end

  // R3
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i));

endmodule

// File: rtl/npi_regs.sv
module npi_regs #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int AW     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_addr_i,
  input  logic [NSRC-1:0]              wr_data_i,
  input  logic [AW-1:0]                rd_addr_i,
  input  logic [NSRC-1:0]              pend_i,
  output logic [NSRC-1:0]              rd_data_o,
  output logic [NSRC-1:0]              en_o,
  output logic [NSRC-1:0][PRIO_W-1:0]  prio_o
);

  logic [NSRC-1:0]             en_q;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic                        en_hit;
  logic [NSRC-1:0]             prio_hit;

  assign en_hit = wr_en_i && (wr_addr_i == AW'(npi_pkg::REG_ENABLE));

  // One write decode per priority register.
  for (genvar g = 0; g < NSRC; g++) begin : g_dec
    assign prio_hit[g] = wr_en_i && (wr_addr_i == AW'(npi_pkg::prio_addr(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      if (en_hit) en_q <= wr_data_i;
      for (int i = 0; i < NSRC; i++) begin
        if (prio_hit[i]) prio_q[i] <= wr_data_i[PRIO_W-1:0];
      end
    end
  end

  // Pending is read only; its address decodes for reads alone.
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(npi_pkg::REG_ENABLE)) rd_data_o = en_q;
    if (rd_addr_i == AW'(npi_pkg::REG_PENDING)) rd_data_o = pend_i;
    for (int i = 0; i < NSRC; i++) begin
      if (rd_addr_i == AW'(npi_pkg::prio_addr(i))) rd_data_o = NSRC'(prio_q[i]);
    end
  end

  assign en_o   = en_q;
  assign prio_o = prio_q;

  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_hit |=> $stable(en_q));
  // R9
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|prio_hit) |=> $stable(prio_q));

endmodule

// File: rtl/npi_arb.sv
module npi_arb #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int LVL_W  = PRIO_W + 1,
  parameter int IDW    = 4
) (
  input  logic [NSRC-1:0]              pend_i,
  input  logic [NSRC-1:0]              en_i,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [LVL_W-1:0]             cur_i,
  output logic                         win_valid_o,
  output logic [IDW-1:0]               win_id_o,
  output logic [LVL_W-1:0]             win_lvl_o
);

  // Programmed priority p maps to service level p+1; level 0 means idle.
  function automatic logic [LVL_W-1:0] lvl_of(input logic [PRIO_W-1:0] p);
    return LVL_W'(p) + LVL_W'(1);
  endfunction

  // Scanning upward with a strict compare keeps the lowest index on ties.
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    win_lvl_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && en_i[i] && (lvl_of(prio_i[i]) > cur_i) &&
          (!win_valid_o || (lvl_of(prio_i[i]) > win_lvl_o))) begin
        win_valid_o = 1'b1;
        win_id_o    = IDW'(i);
        win_lvl_o   = lvl_of(prio_i[i]);
      end
    end
  end

endmodule

// File: rtl/npi_lvl_stack.sv
module npi_lvl_stack #(
  parameter int NLVL  = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] cur_o,
  output logic             err_o
);

  localparam int SP_W  = $clog2(NLVL + 1);
  localparam int STK_N = 1 << SP_W;

  logic [LVL_W-1:0] stk [STK_N];
  logic [SP_W-1:0]  sp;
  logic [LVL_W-1:0] cur;
  logic             err;
  logic             push_ev;
  logic             pop_ev;
  logic             bad_ev;

  assign push_ev = push_i;
  assign pop_ev  = pop_i && (sp != '0);
  assign bad_ev  = pop_i && (sp == '0);

  // Entries are only read after being written, so they need no reset.
  always_ff @(posedge clk) begin
    if (push_ev) stk[sp] <= cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      cur <= '0;
      err <= 1'b0;
    end else begin
      if (push_ev) begin
        sp  <= sp + SP_W'(1);
        cur <= push_lvl_i;
      end else if (pop_ev) begin
        sp  <= sp - SP_W'(1);
        cur <= stk[sp - SP_W'(1)];
      end
      if (bad_ev) err <= 1'b1;
    end
  end

  assign cur_o = cur;
  assign err_o = err;

  // R10
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(NLVL));
  // R5
  push_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |-> (push_lvl_i > cur));
  // R4
  push_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (cur == $past(push_lvl_i)) && (sp == $past(sp) + SP_W'(1)));
  // R6
  pop_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> (cur < $past(cur)) && (sp == $past(sp) - SP_W'(1)));
  // R7
  bad_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ev |=> err && (cur == $past(cur)));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/nest_prio_irq.sv
module nest_prio_irq #(
  parameter  int NSRC   = 8,
  parameter  int PRIO_W = 3,
  parameter  int AW     = $clog2(NSRC + 2),
  localparam int LVL_W  = PRIO_W + 1,
  localparam int IDW    = $clog2(NSRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [NSRC-1:0]  wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [NSRC-1:0]  rd_data_o,
  input  logic             ack_i,
  output logic [IDW-1:0]   ack_id_o,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic             eoi_err_o
);

  localparam int NLVL  = 1 << PRIO_W;
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]             pend;
  logic [NSRC-1:0]             rise;
  logic [NSRC-1:0]             en;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic [NSRC-1:0]             clr;
  logic                        win_valid;
  logic [IDW-1:0]              win_id;
  logic [LVL_W-1:0]            win_lvl;
  logic [LVL_W-1:0]            cur_lvl;
  logic                        take_ev;
  logic                        eoi_ev;

  // Named events: an acknowledge that finds a winner, and an accepted EOI.
  assign take_ev = ack_i && win_valid;
  assign eoi_ev  = eoi_i && !ack_i;
  assign clr     = take_ev ? (NSRC'(1) << win_id) : '0;

  npi_pend #(.NSRC(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .clr_i  (clr),
    .rise_o (rise),
    .pend_o (pend)
  );

  npi_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .pend_i    (pend),
    .rd_data_o (rd_data_o),
    .en_o      (en),
    .prio_o    (prio)
  );

  npi_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .LVL_W(LVL_W), .IDW(IDW)) u_arb (
    .pend_i      (pend),
    .en_i        (en),
    .prio_i      (prio),
    .cur_i       (cur_lvl),
    .win_valid_o (win_valid),
    .win_id_o    (win_id),
    .win_lvl_o   (win_lvl)
  );

  npi_lvl_stack #(.NLVL(NLVL), .LVL_W(LVL_W)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (take_ev),
    .push_lvl_i (win_lvl),
    .pop_i      (eoi_ev),
    .cur_o      (cur_lvl),
    .err_o      (eoi_err_o)
  );

  assign irq_o     = win_valid;
  assign ack_id_o  = win_valid ? win_id : {IDW{1'b1}};
  assign cur_lvl_o = cur_lvl;

  // R1
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en[win_id[IDX_W-1:0]] && pend[win_id[IDX_W-1:0]]);
  // R5
  irq_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_lvl > cur_lvl));
  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_i) |=> $stable(cur_lvl));
  // R11
  ack_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && eoi_i && !irq_o) |=> $stable(cur_lvl) && $stable(eoi_err_o));

endmodule

// File: tb/tb_nest_prio_irq.sv
`timescale 1ns/1ps
module tb_nest_prio_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_i = '0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       ack_i = 1'b0;
  logic [3:0] ack_id_o;
  logic       eoi_i = 1'b0;
  logic       irq_o;
  logic [3:0] cur_lvl_o;
  logic       eoi_err_o;

  always #2 clk = ~clk;

  nest_prio_irq dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .ack_i(ack_i), .ack_id_o(ack_id_o), .eoi_i(eoi_i),
    .irq_o(irq_o), .cur_lvl_o(cur_lvl_o), .eoi_err_o(eoi_err_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state.
  bit [7:0] m_en, m_pend, m_srcq;
  int       m_prio [8];
  int       m_cur, m_sp;
  int       m_stk [16];
  bit       m_err;

  task automatic chk(input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // Highest eligible level first, then the lowest index at that level.
  function automatic int model_win();
    int top = 0;
    for (int i = 0; i < 8; i++)
      if (m_pend[i] && m_en[i] && (m_prio[i] + 1 > m_cur) && (m_prio[i] + 1 > top))
        top = m_prio[i] + 1;
    if (top == 0) return 15;
    for (int i = 0; i < 8; i++)
      if (m_pend[i] && m_en[i] && (m_prio[i] + 1 == top)) return i;
    return 15;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_i = '0; ack_i = 0; eoi_i = 0; wr_en_i = 0;
    m_en = '0; m_pend = '0; m_srcq = '0; m_cur = 0; m_sp = 0; m_err = 0;
    for (int i = 0; i < 8; i++) m_prio[i] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [7:0] s, input bit a, input bit e, input bit w,
                      input logic [3:0] wa, input logic [7:0] wd, input string tag);
    int exp_id;
    bit [7:0] rise;
    @(negedge clk);
    src_i = s; ack_i = a; eoi_i = e; wr_en_i = w; wr_addr_i = wa; wr_data_i = wd;
    #1;
    exp_id = model_win();
    chk(int'(ack_id_o), exp_id, {tag, " ack_id before edge"});
    chk(int'(irq_o), int'(exp_id != 15), {tag, " irq before edge"});
    rise = s & ~m_srcq;
    if (a && exp_id != 15) begin
      m_stk[m_sp] = m_cur;
      m_sp++;
      m_cur = m_prio[exp_id] + 1;
      m_pend[exp_id] = 1'b0;
    end else if (!a && e) begin
      if (m_sp == 0) m_err = 1'b1;
      else begin
        m_sp--;
        m_cur = m_stk[m_sp];
      end
    end
    m_pend = m_pend | rise;
    m_srcq = s;
    if (w) begin
      if (wa == 4'd0) m_en = wd;
      else if (wa >= 4'd2 && wa < 4'd10) m_prio[wa - 4'd2] = int'(wd[2:0]);
    end
    @(posedge clk);
    #0.5;
    ack_i = 0; eoi_i = 0; wr_en_i = 0; rd_addr_i = 4'd1;
    #0.5;
    chk(int'(cur_lvl_o), m_cur, {tag, " level"});
    chk(int'(eoi_err_o), int'(m_err), {tag, " eoi error flag"});
    chk(int'(rd_data_o), int'(m_pend), {tag, " pending"});
    chk(int'(ack_id_o), model_win(), {tag, " ack_id after edge"});
  endtask

  task automatic rd_chk(input logic [3:0] addr, input int exp, input string tag);
    @(negedge clk);
    rd_addr_i = addr;
    #1;
    chk(int'(rd_data_o), exp, tag);
  endtask

  task automatic set_en(input logic [7:0] v);
    step(m_srcq, 0, 0, 1, 4'd0, v, "R9 enable write");
  endtask
  task automatic set_prio(input int i, input int p);
    step(m_srcq, 0, 0, 1, 4'(2 + i), 8'(p), "R9 priority write");
  endtask
  task automatic pulse(input int i, input string tag);
    step(m_srcq | (8'd1 << i), 0, 0, 0, 4'd0, 8'd0, tag);
    step(m_srcq & ~(8'd1 << i), 0, 0, 0, 4'd0, 8'd0, tag);
  endtask
  task automatic ack(input string tag);
    step(m_srcq, 1, 0, 0, 4'd0, 8'd0, tag);
  endtask
  task automatic eoi(input string tag);
    step(m_srcq, 0, 1, 0, 4'd0, 8'd0, tag);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;
    do_reset();

    // Reset state: idle, no request, registers clear (R1, R9)
    #1;
    chk(int'(irq_o), 0, "R1 reset irq");
    chk(int'(ack_id_o), 15, "R3 reset ack_id none code");
    chk(int'(cur_lvl_o), 0, "R1 reset level");
    chk(int'(eoi_err_o), 0, "R7 reset error flag");
    for (int a = 0; a < 16; a++) rd_chk(4'(a), 0, "R9 reset register read");

    // Register map sweep (R9)
    for (int i = 0; i < 8; i++) set_prio(i, (i * 3) % 8);
    for (int i = 0; i < 8; i++) rd_chk(4'(2 + i), (i * 3) % 8, "R9 priority readback");
    set_en(8'hA5);
    rd_chk(4'd0, 8'hA5, "R9 enable readback");
    step(m_srcq, 0, 0, 1, 4'd1, 8'hFF, "R9 pending write");
    rd_chk(4'd1, 0, "R9 pending write has no effect");
    for (int a = 10; a < 16; a++) rd_chk(4'(a), 0, "R9 unmapped read zero");

    // Every source at every priority (R2, R3, R4, R6)
    do_reset();
    set_en(8'hFF);
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 8; p++) begin
        set_prio(i, p);
        pulse(i, "R2 single edge");
        ack("R3 R4 single source");
        chk(int'(cur_lvl_o), p + 1, "R4 level raised to priority+1");
        eoi("R6 single restore");
        chk(int'(cur_lvl_o), 0, "R6 level back to idle");
      end
    end

    // Every pending subset with tied priorities, drained in order (R3, R5)
    do_reset();
    set_en(8'hFF);
    for (int i = 0; i < 8; i++) set_prio(i, (i % 4) * 2);
    for (int pat = 1; pat < 256; pat++) begin
      step(8'(pat), 0, 0, 0, 4'd0, 8'd0, "R3 subset edges");
      step(8'd0, 0, 0, 0, 4'd0, 8'd0, "R3 subset release");
      while (model_win() != 15) begin
        ack("R3 subset winner");
        chk(int'(irq_o), int'(model_win() != 15), "R5 same level blocked");
        eoi("R6 subset restore");
      end
    end

    // Full nesting chain, unwind, empty EOI (R10, R5, R6, R7)
    do_reset();
    set_en(8'hFF);
    for (int i = 0; i < 8; i++) set_prio(i, i);
    for (int i = 0; i < 8; i++) begin
      pulse(i, "R10 chain edge");
      ack("R10 chain acknowledge");
      chk(int'(cur_lvl_o), i + 1, "R10 chain level");
    end
    chk(int'(cur_lvl_o), 8, "R10 full depth");
    pulse(0, "R5 lower edge");
    chk(int'(irq_o), 0, "R5 lower source blocked");
    for (int k = 7; k >= 0; k--) begin
      eoi("R6 unwind");
      chk(int'(cur_lvl_o), k, "R6 unwind level");
    end
    chk(int'(irq_o), 1, "R5 lower source released at idle");
    ack("R5 late acknowledge");
    eoi("R6 late restore");
    eoi("R7 empty stack");
    chk(int'(eoi_err_o), 1, "R7 error flag set");
    chk(int'(cur_lvl_o), 0, "R7 level unchanged");
    pulse(3, "R7 activity after error");
    chk(int'(eoi_err_o), 1, "R7 error flag sticky");
    do_reset();
    #1;
    chk(int'(eoi_err_o), 0, "R7 error flag cleared by reset");

    // Disabled source latches pending (R12)
    set_en(8'hF7);
    set_prio(3, 2);
    pulse(3, "R12 disabled edge");
    chk(int'(irq_o), 0, "R12 disabled no request");
    rd_chk(4'd1, 8'h08, "R12 pending latched while disabled");
    set_en(8'hFF);
    chk(int'(irq_o), 1, "R12 request after enable");
    chk(int'(ack_id_o), 3, "R12 enabled source wins");

    // Level held high is not re-latched (R2)
    do_reset();
    set_en(8'hFF);
    set_prio(5, 1);
    step(8'h20, 0, 0, 0, 4'd0, 8'd0, "R2 held rise");
    step(8'h20, 1, 0, 0, 4'd0, 8'd0, "R2 held acknowledge");
    repeat (3) step(8'h20, 0, 0, 0, 4'd0, 8'd0, "R2 held high");
    rd_chk(4'd1, 0, "R2 held level no second pending");
    eoi("R2 held restore");

    // Edge together with acknowledge of the same source (R13)
    do_reset();
    set_en(8'hFF);
    set_prio(2, 3);
    pulse(2, "R13 first edge");
    step(8'h04, 1, 0, 0, 4'd0, 8'd0, "R13 edge at acknowledge");
    rd_chk(4'd1, 8'h04, "R13 pending kept");
    chk(int'(irq_o), 0, "R13 same level blocked");
    step(8'h00, 0, 0, 0, 4'd0, 8'd0, "R13 release");
    eoi("R13 restore");
    chk(int'(ack_id_o), 2, "R13 second request visible");

    // Acknowledge with no eligible source (R8)
    do_reset();
    set_en(8'hFF);
    set_prio(3, 5);
    set_prio(1, 2);
    pulse(3, "R8 high edge");
    ack("R8 high acknowledge");
    pulse(1, "R8 low edge");
    chk(int'(irq_o), 0, "R8 low blocked");
    ack("R8 empty acknowledge");
    chk(int'(cur_lvl_o), 6, "R8 level unchanged");
    rd_chk(4'd1, 8'h02, "R8 pending unchanged");
    eoi("R8 restore");
    chk(int'(ack_id_o), 1, "R8 low source after restore");

    // Acknowledge and EOI together (R11)
    do_reset();
    set_en(8'hFF);
    set_prio(0, 4);
    pulse(0, "R11 edge");
    step(m_srcq, 1, 1, 0, 4'd0, 8'd0, "R11 both with winner");
    chk(int'(cur_lvl_o), 5, "R11 acknowledge taken, no restore");
    step(m_srcq, 1, 1, 0, 4'd0, 8'd0, "R11 both without winner");
    chk(int'(cur_lvl_o), 5, "R11 EOI dropped");
    eoi("R11 restore");
    step(m_srcq, 1, 1, 0, 4'd0, 8'd0, "R11 both on empty stack");
    chk(int'(eoi_err_o), 0, "R11 no error when acknowledge present");

    // Mixed pseudo-random traffic against the model (R1, R3, R4, R6)
    do_reset();
    set_en(8'hFF);
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < 8; b++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(m_srcq ^ (lf[7:0] & lf[15:8]), lf[3] & lf[9], lf[5] & lf[11] & lf[1],
           (lf[2:0] == 3'd0), lf[13] ? 4'(2 + lf[10:8]) : 4'd0,
           lf[13] ? lf[15:8] : (lf[15:8] | 8'h3C), "R1 R3 R4 R6 mixed traffic");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule